// File: doc/BRIEF.md
# Forward-Link Command Encoder

This block drives the reader field of a low-frequency reader so that a nearby EEPROM transponder receives one of four commands: login with a password, read a word, write a word, or disable. The host places a command select, a 6-bit word address and a 32-bit value on the inputs and pulses `start`. The block builds the whole bit frame in one cycle, parity included, and loads it into a shift register. It then plays the frame out as field-on and field-off intervals. All intervals are counted in ticks of a 1 µs strobe, so the system clock rate does not affect the waveform.

A frame opens with a start bit. That bit is never sent as a symbol; a long field gap followed by a short field burst takes its place. After that, a 1 bit keeps the field up for a full bit time, and a 0 bit cuts a short notch into the field. A write keeps the field up for a long programming hold after its last bit. A read leaves the field up when it finishes and flags the receive path with a single-cycle pulse. A login or a disable drops the field as soon as the last bit ends.

The controller is one state machine with seven states. `S_IDLE` goes to `S_LEAD_OFF` on `start`. `S_LEAD_OFF` goes to `S_LEAD_ON` when its timer expires. When `S_LEAD_ON`, `S_MARK_ON` or `S_NOTCH_ON` expires, the next frame bit selects `S_MARK_ON` (bit 1) or `S_NOTCH_OFF` (bit 0). If no bits are left, a write goes to `S_PROG_HOLD` and every other command goes to `S_IDLE`. `S_NOTCH_OFF` goes to `S_NOTCH_ON` on expiry, and `S_PROG_HOLD` goes to `S_IDLE` on expiry.

Top module: `fl_cmd_encoder`

## Requirements
- R1: During and directly after reset, `field_on`, `busy` and `acq_start` are all 0.
- R2: The frame opens with a start bit of 0. The 4-bit command code follows, least significant bit first. The codes are `op_sel` 0 = login 0xC, 1 = write 0xA, 2 = read 0x9 and 3 = disable 0x5.
- R3: Read and write frames carry the 6 address bits next, least significant first, followed by one parity bit equal to the XOR of those 6 bits.
- R4: Login and write frames carry the 32-bit value as four bytes, low byte first. Each byte is sent least significant bit first and is followed by its even parity bit (the XOR of the byte). Then come the XOR of the four bytes as a column byte, least significant bit first, and finally a 0 stop bit.
- R5: The start bit is replaced by the field off for 480 ticks and then on for 16 ticks.
- R6: Every later 1 bit holds the field on for 256 ticks.
- R7: Every later 0 bit turns the field off for 20 ticks and then on for 12 ticks.
- R8: A login or a disable returns to idle straight after its last bit, with the field off and no pulse on `acq_start`.
- R9: A write holds the field on for 20000 ticks after its last bit, then returns to idle with the field off.
- R10: A read returns to idle straight after its last bit with the field left on. `acq_start` is high for exactly the first idle cycle.
- R11: `busy` rises in the cycle after an accepted `start` and stays high until the block returns to idle. A `start` while busy is ignored.
- R12: Intervals count only cycles in which `tick_us` is high. The field does not change in a busy cycle that has no tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle strobe every microsecond |
| start | input | 1 | Begin a command (accepted when idle) |
| op_sel | input | 2 | Command select: 0 login, 1 write, 2 read, 3 disable |
| addr | input | 6 | Word address for read and write |
| wdata | input | 32 | Password for login, word value for write |
| field_on | output | 1 | Reader field enable |
| busy | output | 1 | Command in progress |
| acq_start | output | 1 | One-cycle pulse when a read has been sent |

## Verification
The checker watches several things on every cycle. It checks that a busy period only begins after `start` and always opens with the field off. It checks that the field and `busy` do not change in a busy cycle without a tick. It checks that `acq_start` is a single-cycle pulse that appears only in the first idle cycle after a busy period, with the field on. Frame content, parity, symbol durations and the end-of-command field level cannot be checked that way. The bench covers them by measuring every field run in ticks and comparing it with runs it derives from the command inputs. It does this at three tick rates, for all four commands, and with a `start` that arrives while the block is busy.

// File: rtl/fl_enc_pkg.sv
package fl_enc_pkg;

    typedef enum logic [1:0] {
        OP_LOGIN   = 2'd0,
        OP_WRITE   = 2'd1,
        OP_READ    = 2'd2,
        OP_DISABLE = 2'd3
    } fl_op_e;

    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_LEAD_OFF  = 3'd1,
        S_LEAD_ON   = 3'd2,
        S_MARK_ON   = 3'd3,
        S_NOTCH_OFF = 3'd4,
        S_NOTCH_ON  = 3'd5,
        S_PROG_HOLD = 3'd6
    } fl_state_e;

    // Command codes already carry parity and are stored in send order (LSB first).
    function automatic logic [3:0] fl_op_code(input fl_op_e op);
        logic [3:0] c;
        unique case (op)
            OP_LOGIN:   c = 4'hC;
            OP_WRITE:   c = 4'hA;
            OP_READ:    c = 4'h9;
            OP_DISABLE: c = 4'h5;
            default:    c = 4'h0;
        endcase
        return c;
    endfunction

    function automatic int fl_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fl_frame_build.sv
module fl_frame_build
    import fl_enc_pkg::*;
#(
    parameter int FRAME_W    = 64,
    parameter int ADDR_W     = 6,
    parameter int DATA_BYTES = 4
) (
    input  fl_op_e                          op,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [8*DATA_BYTES-1:0]         data,
    output logic [FRAME_W-1:0]              frame,
    output logic [$clog2(FRAME_W+1)-1:0]    frame_len
);

    localparam int LEN_W = $clog2(FRAME_W + 1);
    localparam int POS_W = $clog2(FRAME_W);

    logic [LEN_W-1:0]         idx;
    logic [3:0]               code_w;
    logic [ADDR_W-1:0]        addr_w;
    logic [8*DATA_BYTES-1:0]  data_w;
    logic [7:0]               byte_w;
    logic [7:0]               col_par;
    logic                     row_par;
    logic                     has_addr;
    logic                     has_data;

    assign has_addr = (op == OP_READ)  || (op == OP_WRITE);
    assign has_data = (op == OP_LOGIN) || (op == OP_WRITE);

    always_comb begin
        frame   = '0;
        idx     = '0;
        code_w  = fl_op_code(op);
        addr_w  = addr;
        data_w  = data;
        byte_w  = '0;
        col_par = '0;
        row_par = 1'b0;

        // start bit (R2)
        frame[idx[POS_W-1:0]] = 1'b0;
        idx = idx + LEN_W'(1);

        // command code, LSB first (R2)
        for (int i = 0; i < 4; i++) begin
            frame[idx[POS_W-1:0]] = code_w[0];
            code_w = code_w >> 1;
            idx = idx + LEN_W'(1);
        end

        // address with line parity (R3)
        if (has_addr) begin
            for (int i = 0; i < ADDR_W; i++) begin
                frame[idx[POS_W-1:0]] = addr_w[0];
                addr_w = addr_w >> 1;
                idx = idx + LEN_W'(1);
            end
            frame[idx[POS_W-1:0]] = ^addr;
            idx = idx + LEN_W'(1);
        end

        // data bytes with row parity, column byte and stop bit (R4)
        if (has_data) begin
            for (int b = 0; b < DATA_BYTES; b++) begin
                byte_w  = data_w[7:0];
                row_par = ^byte_w;
                col_par = col_par ^ byte_w;
                for (int i = 0; i < 8; i++) begin
                    frame[idx[POS_W-1:0]] = byte_w[0];
                    byte_w = byte_w >> 1;
                    idx = idx + LEN_W'(1);
                end
                frame[idx[POS_W-1:0]] = row_par;
                idx = idx + LEN_W'(1);
                data_w = data_w >> 8;
            end
            byte_w = col_par;
            for (int i = 0; i < 8; i++) begin
                frame[idx[POS_W-1:0]] = byte_w[0];
                byte_w = byte_w >> 1;
                idx = idx + LEN_W'(1);
            end
            frame[idx[POS_W-1:0]] = 1'b0;
            idx = idx + LEN_W'(1);
        end

        frame_len = idx;
    end

endmodule

// File: rtl/fl_bit_queue.sv
module fl_bit_queue #(
    parameter int FRAME_W = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [FRAME_W-1:0]            frame,
    input  logic [$clog2(FRAME_W+1)-1:0]  frame_len,
    input  logic                          pop,
    output logic                          head,
    output logic                          more
);

    localparam int LEN_W = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] bits_q;
    logic [LEN_W-1:0]   left_q;

    // The start bit (frame[0]) is consumed by the lead-in, so it is dropped here.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
            left_q <= '0;
        end else if (load) begin
            bits_q <= frame >> 1;
            left_q <= (frame_len == '0) ? '0 : frame_len - LEN_W'(1);
        end else if (pop && (left_q != '0)) begin
            bits_q <= bits_q >> 1;
            left_q <= left_q - LEN_W'(1);
        end
    end

    assign head = bits_q[0];
    assign more = (left_q != '0);

endmodule

// File: rtl/fl_tick_timer.sv
module fl_tick_timer #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expire = tick && (cnt_q == CNT_W'(1));

endmodule

// File: rtl/fl_cmd_encoder.sv
module fl_cmd_encoder
    import fl_enc_pkg::*;
#(
    parameter int FRAME_W      = 64,
    parameter int ADDR_W       = 6,
    parameter int DATA_BYTES   = 4,
    parameter int LEAD_OFF_US  = 480,
    parameter int LEAD_ON_US   = 16,
    parameter int MARK_ON_US   = 256,
    parameter int NOTCH_OFF_US = 20,
    parameter int NOTCH_ON_US  = 12,
    parameter int PROG_HOLD_US = 20000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick_us,
    input  logic                      start,
    input  logic [1:0]                op_sel,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [8*DATA_BYTES-1:0]   wdata,
    output logic                      field_on,
    output logic                      busy,
    output logic                      acq_start
);

    localparam int LEN_W   = $clog2(FRAME_W + 1);
    localparam int MAX_DUR = fl_max(fl_max(fl_max(LEAD_OFF_US, LEAD_ON_US),
                                           fl_max(MARK_ON_US, NOTCH_OFF_US)),
                                    fl_max(NOTCH_ON_US, PROG_HOLD_US));
    localparam int CNT_W   = $clog2(MAX_DUR + 1);

    fl_state_e           state_q, state_d;
    fl_op_e              op_q;
    logic                idle_field_q;
    logic                acq_q;

    logic [FRAME_W-1:0]  frame;
    logic [LEN_W-1:0]    frame_len;
    logic                load_frame;
    logic                pop_bit;
    logic                head_bit;
    logic                more_bits;

    logic                tmr_load;
    logic [CNT_W-1:0]    tmr_val;
    logic                tmr_expire;

    logic                finish;

    fl_frame_build #(
        .FRAME_W    (FRAME_W),
        .ADDR_W     (ADDR_W),
        .DATA_BYTES (DATA_BYTES)
    ) u_build (
        .op        (fl_op_e'(op_sel)),
        .addr      (addr),
        .data      (wdata),
        .frame     (frame),
        .frame_len (frame_len)
    );

    fl_bit_queue #(
        .FRAME_W (FRAME_W)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_frame),
        .frame     (frame),
        .frame_len (frame_len),
        .pop       (pop_bit),
        .head      (head_bit),
        .more      (more_bits)
    );

    fl_tick_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_us),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_expire)
    );

    // Next-state logic
    always_comb begin
        state_d    = state_q;
        load_frame = 1'b0;
        pop_bit    = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        finish     = 1'b0;

        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    load_frame = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = CNT_W'(LEAD_OFF_US);
                    state_d    = S_LEAD_OFF;
                end
            end
            S_LEAD_OFF: begin
                if (tmr_expire) begin
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(LEAD_ON_US);
                    state_d  = S_LEAD_ON;
                end
            end
            S_LEAD_ON, S_MARK_ON, S_NOTCH_ON: begin
                if (tmr_expire) begin
                    if (more_bits) begin
                        pop_bit  = 1'b1;
                        tmr_load = 1'b1;
                        if (head_bit) begin
                            tmr_val = CNT_W'(MARK_ON_US);
                            state_d = S_MARK_ON;
                        end else begin
                            tmr_val = CNT_W'(NOTCH_OFF_US);
                            state_d = S_NOTCH_OFF;
                        end
                    end else if (op_q == OP_WRITE) begin
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(PROG_HOLD_US);
                        state_d  = S_PROG_HOLD;
                    end else begin
                        finish  = 1'b1;
                        state_d = S_IDLE;
                    end
                end
            end
            S_NOTCH_OFF: begin
                if (tmr_expire) begin
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(NOTCH_ON_US);
                    state_d  = S_NOTCH_ON;
                end
            end
            S_PROG_HOLD: begin
                if (tmr_expire) begin
                    finish  = 1'b1;
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= S_IDLE;
            op_q         <= OP_LOGIN;
            idle_field_q <= 1'b0;
            acq_q        <= 1'b0;
        end else begin
            state_q <= state_d;
            acq_q   <= finish && (op_q == OP_READ);
            if (load_frame) begin
                op_q <= fl_op_e'(op_sel);
            end
            if (finish) begin
                idle_field_q <= (op_q == OP_READ);
            end
        end
    end

    // Outputs
    always_comb begin
        field_on = 1'b1;
        busy     = 1'b1;
        unique case (state_q)
            S_IDLE: begin
                field_on = idle_field_q;
                busy     = 1'b0;
            end
            S_LEAD_OFF, S_NOTCH_OFF: field_on = 1'b0;
            S_LEAD_ON, S_MARK_ON, S_NOTCH_ON, S_PROG_HOLD: field_on = 1'b1;
            default: begin
                field_on = 1'b0;
                busy     = 1'b0;
            end
        endcase
    end

    assign acq_start = acq_q;

endmodule

// File: rtl/fl_cmd_encoder_chk.sv
module fl_cmd_encoder_chk (
    input logic clk,
    input logic rst_n,
    input logic tick_us,
    input logic start,
    input logic field_on,
    input logic busy,
    input logic acq_start
);

    a_r11_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    a_r5_lead_in_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !field_on);

    a_r12_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick_us) |=> (busy && $stable(field_on)));

    a_r10_acq_single: assert property (@(posedge clk) disable iff (!rst_n)
        acq_start |=> !acq_start);

    a_r10_acq_at_finish: assert property (@(posedge clk) disable iff (!rst_n)
        acq_start |-> (!busy && field_on && $past(busy)));

endmodule

bind fl_cmd_encoder fl_cmd_encoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_us   (tick_us),
    .start     (start),
    .field_on  (field_on),
    .busy      (busy),
    .acq_start (acq_start)
);

// File: tb/tb_fl_cmd_encoder.sv
module tb_fl_cmd_encoder;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_us = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op_sel = 2'd0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        field_on;
    logic        busy;
    logic        acq_start;

    int n_cmp = 0;
    int n_bad = 0;
    int tick_div = 1;
    int tick_ph = 0;
    bit finished = 0;

    typedef struct {
        bit    lvl;
        int    len;
        string tag;
    } run_t;

    run_t exp_q[$];

    fl_cmd_encoder dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_us   (tick_us),
        .start     (start),
        .op_sel    (op_sel),
        .addr      (addr),
        .wdata     (wdata),
        .field_on  (field_on),
        .busy      (busy),
        .acq_start (acq_start)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // tick strobe: one cycle in every tick_div
    always begin
        @(posedge clk);
        #1;
        tick_us = (tick_ph == 0);
        tick_ph = (tick_ph + 1 >= tick_div) ? 0 : tick_ph + 1;
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic add_seg(input bit lvl, input int len, input string tag);
        if (exp_q.size() > 0 && exp_q[exp_q.size()-1].lvl == lvl)
            exp_q[exp_q.size()-1].len += len;
        else
            exp_q.push_back('{lvl, len, tag});
    endtask

    task automatic add_bit(input bit b, input string tag);
        if (b) add_seg(1'b1, 256, tag);          // R6
        else begin
            add_seg(1'b0, 20, tag);              // R7
            add_seg(1'b1, 12, tag);
        end
    endtask

    // Driver: derive expected field runs from the command, then issue it.
    task automatic issue(input int op, input logic [5:0] a, input logic [31:0] d,
                         input int div, input bit poke);
        logic [3:0] codes [4] = '{4'hC, 4'hA, 4'h9, 4'h5};
        logic [7:0] col;
        logic [7:0] by;
        tick_div = div;
        add_seg(1'b0, 480, "R5");                // start bit replaced by lead-in
        add_seg(1'b1, 16, "R5");
        for (int i = 0; i < 4; i++) add_bit(codes[op][i], "R2");
        if (op == 1 || op == 2) begin
            for (int i = 0; i < 6; i++) add_bit(a[i], "R3");
            add_bit(^a, "R3");
        end
        if (op == 0 || op == 1) begin
            col = '0;
            for (int b = 0; b < 4; b++) begin
                by = d[8*b +: 8];
                col = col ^ by;
                for (int i = 0; i < 8; i++) add_bit(by[i], "R4");
                add_bit(^by, "R4");
            end
            for (int i = 0; i < 8; i++) add_bit(col[i], "R4");
            add_bit(1'b0, "R4");
        end
        if (op == 1) add_seg(1'b1, 20000, "R9");

        @(posedge clk); #2;
        op_sel = 2'(op); addr = a; wdata = d; start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
        check("R11", int'(busy), 1, "busy after start");
        if (poke) begin
            repeat (300) @(posedge clk);
            #2;
            op_sel = 2'd2; addr = 6'h3F; wdata = 32'hFFFF_FFFF; start = 1'b1;
            @(posedge clk); #2;
            start = 1'b0;
            check("R11", int'(busy), 1, "busy after ignored start");
        end
        do @(negedge clk); while (busy && !finished);
        #1;
        check(op == 2 ? "R10" : "R8", int'(acq_start), (op == 2) ? 1 : 0, "acq_start first idle cycle");
        check(op == 2 ? "R10" : (op == 1 ? "R9" : "R8"), int'(field_on), (op == 2) ? 1 : 0,
              "field level in idle");
        @(negedge clk); #1;
        check("R10", int'(acq_start), 0, "acq_start second idle cycle");
        check("R11", exp_q.size(), 0, "expected runs left over");
        exp_q.delete();
    endtask

    // Monitor: measures each field run in ticks while busy and scores it.
    bit prev_busy = 0;
    bit cur_lvl = 0;
    int cur_len = 0;

    task automatic score_run();
        run_t e;
        if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R11 unexpected run: actual lvl %0d len %0d expected none", cur_lvl, cur_len);
        end else begin
            e = exp_q.pop_front();
            check(e.tag, int'(cur_lvl), int'(e.lvl), "run level");
            check(e.tag, cur_len, e.len, "run length in ticks (R12)");
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) begin
                if (!prev_busy) begin
                    cur_lvl = field_on;
                    cur_len = 0;
                end else if (field_on != cur_lvl) begin
                    score_run();
                    cur_lvl = field_on;
                    cur_len = 0;
                end
                if (tick_us) cur_len++;
            end else if (prev_busy) begin
                score_run();
            end
            prev_busy = busy;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", int'(field_on), 0, "field during reset");
        check("R1", int'(busy), 0, "busy during reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", int'(field_on), 0, "field after reset");
        check("R1", int'(busy), 0, "busy after reset");
        check("R1", int'(acq_start), 0, "acq_start after reset");

        issue(0, 6'h00, 32'hA5C3_0F12, 1, 1'b1);   // login, with ignored start
        issue(2, 6'h15, 32'h0, 3, 1'b0);           // read, slow tick
        issue(3, 6'h00, 32'h0, 2, 1'b0);           // disable
        issue(1, 6'h2A, 32'h0000_0001, 1, 1'b0);   // write with hold
        issue(2, 6'h00, 32'h0, 1, 1'b0);           // read, zero address

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule